// File: doc/BRIEF.md
# Debug Trigger Match and Chaining Unit

This block evaluates ten breakpoint triggers against the memory and fetch events of one instruction slot. Each trigger compares a 64-bit value against one fixed address stream: a fetch PC, a load address or a store address. The triggers are grouped in five fixed pairs. A pair may be chained, so that its members fire only together. Per-trigger match and fire vectors come out in the same cycle as the event. They are joined into one trap request, which says whether the trap belongs to the current instruction or the next one, and whether any firing trigger asks for the debug action.

Software programs each trigger through a single write port. Each write carries a trigger index, an enable, a 2-bit match type, a select bit, a timing bit, an action bit, a chain bit and the compare value. A write changes the behaviour from the next clock cycle onward.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset every trigger is disabled and every chain bit is cleared, so `match_vec`, `fire_vec`, `trap_req`, `trap_timing` and `trap_action` are all 0 whatever the events are.
- R2: Match type encoding, with the address and the value treated as unsigned:
  - 0 is equality.
  - 1 is a masked equality. The trailing one bits of the value and the first zero bit above them are ignored; for example, value 0x2007 covers 0x2000 to 0x200F.
  - 2 is address >= value.
  - 3 is address < value.
- R3: Trigger k compares only its own event, and only while that event's valid input is high. Triggers 0, 1, 6 and 8 use the fetch PC. Triggers 2, 3 and 7 use the store address. Triggers 4, 5 and 9 use the load address.
- R4: Pair g holds triggers 2g (bit 2g) and 2g+1. The pair is chained when either member's chain bit is set. A chained pair fires only if both members match, and this holds even when the two members watch different event sources.
- R5: A chained pair whose two members have different timing bits never fires, even when both members match.
- R6: Pair 1 (triggers 2 and 3, both store) ignores its chain bits: each of its triggers fires whenever it matches.
- R7: `trap_req` is the OR of `fire_vec`. `trap_timing` is 1 only when a trap is requested and every firing trigger has timing 1; otherwise it is 0. `trap_action` is the OR of the action bits of the firing triggers.
- R8: A configuration write with `cfg_we` high stores the fields into the trigger named by `cfg_idx`. The new setting is used from the next cycle; in the write cycle the old setting still applies. Indices 10 to 15 change nothing.
- R9: A trigger whose select bit is 1 requests a data compare, which this block does not support, so it never matches.
- R10: Bit k of `match_vec` shows the raw match of trigger k: enabled, event valid, select 0 and compare true. Chaining does not affect it. `fire_vec` is never set where `match_vec` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Trigger index to write |
| cfg_en | input | 1 | Trigger enable |
| cfg_mtype | input | 2 | Match type (R2 encoding) |
| cfg_sel | input | 1 | 1 = data compare (never matches) |
| cfg_timing | input | 1 | 0 = trap on this instruction, 1 = on the next |
| cfg_action | input | 1 | Action request bit |
| cfg_chain | input | 1 | Chain request bit |
| cfg_value | input | 64 | Compare value |
| fetch_vld | input | 1 | Fetch event valid |
| fetch_pc | input | 64 | Fetch PC |
| load_vld | input | 1 | Load event valid |
| load_addr | input | 64 | Load address |
| store_vld | input | 1 | Store event valid |
| store_addr | input | 64 | Store address |
| match_vec | output | 10 | Raw per-trigger match |
| fire_vec | output | 10 | Per-trigger fire after chaining |
| trap_req | output | 1 | Any trigger fired |
| trap_timing | output | 1 | Trap timing of the combined request |
| trap_action | output | 1 | Action of the combined request |

## Verification
Match, fire and trap outputs are combinational from the events and the stored setting, so their result is due in the same cycle the event is driven. A configuration write is due one cycle later. The bench drives each vector on the falling edge and compares a quarter period later, before the next rising edge. Where a write and an event share a cycle, it expects the old setting, and the following vector shows the new one.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int NUM_GRP  = 5;
  localparam int NUM_TRIG = 2 * NUM_GRP;
  localparam int IDX_W    = 4;
  localparam int VAL_W    = 64;

  typedef enum logic [1:0] {
    MT_EQ    = 2'd0,
    MT_NAPOT = 2'd1,
    MT_GE    = 2'd2,
    MT_LT    = 2'd3
  } mtype_e;

  typedef enum logic [1:0] {
    SRC_FETCH = 2'd0,
    SRC_LOAD  = 2'd1,
    SRC_STORE = 2'd2
  } src_e;

  typedef struct packed {
    logic             en;
    mtype_e           mtype;
    logic             sel;
    logic             timing;
    logic             action;
    logic             chain;
    logic [VAL_W-1:0] value;
  } trig_cfg_t;

  // fixed event source of each trigger
  function automatic src_e src_of(input int trig);
    case (trig)
      0, 1, 6, 8: return SRC_FETCH;
      2, 3, 7:    return SRC_STORE;
      default:    return SRC_LOAD;
    endcase
  endfunction

  // a pair made of two store triggers may not chain
  function automatic bit chain_allowed(input int grp);
    return !(src_of(2*grp) == SRC_STORE && src_of(2*grp+1) == SRC_STORE);
  endfunction

  // bits that take part in a masked compare: trailing ones and the first zero drop out
  function automatic logic [VAL_W-1:0] napot_care(input logic [VAL_W-1:0] v);
    return ~(v ^ (v + VAL_W'(1)));
  endfunction

  function automatic logic cmp_hit(input mtype_e mt, input logic [VAL_W-1:0] a,
                                   input logic [VAL_W-1:0] v);
    case (mt)
      MT_EQ:    return a == v;
      MT_NAPOT: return ((a ^ v) & napot_care(v)) == '0;
      MT_GE:    return a >= v;
      default:  return a < v;
    endcase
  endfunction

  function automatic logic [NUM_TRIG-1:0] src_mask(input src_e s);
    logic [NUM_TRIG-1:0] m;
    for (int k = 0; k < NUM_TRIG; k++) m[k] = (src_of(k) == s);
    return m;
  endfunction
endpackage

// File: rtl/dtu_cfg_bank.sv
module dtu_cfg_bank
  import dtu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_vld,
  input  logic [IDX_W-1:0] wr_idx,
  input  trig_cfg_t        wr_cfg,
  output trig_cfg_t        cfg_o [NUM_TRIG]
);
  trig_cfg_t cfg_q [NUM_TRIG];

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_slot
    logic hit_slot;
    assign hit_slot = wr_vld && (wr_idx == IDX_W'(t));

    always_ff @(posedge clk) begin
      if (!rst_n) cfg_q[t] <= '0;
      else if (hit_slot) cfg_q[t] <= wr_cfg;
    end

    a_r8_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vld && wr_idx == IDX_W'(t) |=> cfg_q[t] == $past(wr_cfg));
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_vld && wr_idx == IDX_W'(t)) |=> $stable(cfg_q[t]));

    assign cfg_o[t] = cfg_q[t];
  end
endmodule

// File: rtl/dtu_cmp.sv
module dtu_cmp
  import dtu_pkg::*;
(
  input  logic             en,
  input  logic             sel,
  input  mtype_e           mtype,
  input  logic [VAL_W-1:0] value,
  input  logic             ev_vld,
  input  logic [VAL_W-1:0] ev_addr,
  output logic             hit
);
  logic cmp_ok;
  assign cmp_ok = cmp_hit(mtype, ev_addr, value);
  // sel = 1 asks for a data compare, which has no input here
  assign hit = en && ev_vld && !sel && cmp_ok;
endmodule

// File: rtl/dtu_pair.sv
module dtu_pair
  import dtu_pkg::*;
#(
  parameter int GRP = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_lo,
  input  logic hit_hi,
  input  logic tim_lo,
  input  logic tim_hi,
  input  logic chain_lo,
  input  logic chain_hi,
  output logic fire_lo,
  output logic fire_hi,
  output logic chained
);
  localparam bit CAN_CHAIN = chain_allowed(GRP);

  logic pair_ok;
  assign chained = (chain_lo || chain_hi) && CAN_CHAIN;
  assign pair_ok = hit_lo && hit_hi && (tim_lo == tim_hi);
  assign fire_lo = chained ? pair_ok : hit_lo;
  assign fire_hi = chained ? pair_ok : hit_hi;

  a_r4_chain_both: assert property (@(posedge clk) disable iff (!rst_n)
    chained && (fire_lo || fire_hi) |-> hit_lo && hit_hi);
  a_r5_timing_agree: assert property (@(posedge clk) disable iff (!rst_n)
    chained && (fire_lo || fire_hi) |-> tim_lo == tim_hi);

  if (!CAN_CHAIN) begin : g_nochain
    a_r6_store_pair_free: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_lo || hit_hi) |-> fire_lo == hit_lo && fire_hi == hit_hi);
  end
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dtu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_idx,
  input  logic        cfg_en,
  input  logic [1:0]  cfg_mtype,
  input  logic        cfg_sel,
  input  logic        cfg_timing,
  input  logic        cfg_action,
  input  logic        cfg_chain,
  input  logic [63:0] cfg_value,
  input  logic        fetch_vld,
  input  logic [63:0] fetch_pc,
  input  logic        load_vld,
  input  logic [63:0] load_addr,
  input  logic        store_vld,
  input  logic [63:0] store_addr,
  output logic [9:0]  match_vec,
  output logic [9:0]  fire_vec,
  output logic        trap_req,
  output logic        trap_timing,
  output logic        trap_action
);
  localparam logic [NUM_TRIG-1:0] FETCH_MASK = src_mask(SRC_FETCH);

  trig_cfg_t wr_cfg;
  trig_cfg_t cfg [NUM_TRIG];
  logic [NUM_TRIG-1:0] tim_vec, act_vec, now_fire;
  logic [NUM_GRP-1:0]  chained;

  assign wr_cfg = '{en: cfg_en, mtype: mtype_e'(cfg_mtype), sel: cfg_sel,
                    timing: cfg_timing, action: cfg_action, chain: cfg_chain,
                    value: cfg_value};

  dtu_cfg_bank u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_vld(cfg_we), .wr_idx(cfg_idx),
    .wr_cfg(wr_cfg), .cfg_o(cfg)
  );

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    logic             ev_vld;
    logic [VAL_W-1:0] ev_addr;
    if (src_of(t) == SRC_FETCH) begin : g_f
      assign ev_vld  = fetch_vld;
      assign ev_addr = fetch_pc;
    end else if (src_of(t) == SRC_STORE) begin : g_s
      assign ev_vld  = store_vld;
      assign ev_addr = store_addr;
    end else begin : g_l
      assign ev_vld  = load_vld;
      assign ev_addr = load_addr;
    end
    dtu_cmp u_cmp (
      .en(cfg[t].en), .sel(cfg[t].sel), .mtype(cfg[t].mtype), .value(cfg[t].value),
      .ev_vld(ev_vld), .ev_addr(ev_addr), .hit(match_vec[t])
    );
    assign tim_vec[t] = cfg[t].timing;
    assign act_vec[t] = cfg[t].action;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    dtu_pair #(.GRP(g)) u_pair (
      .clk(clk), .rst_n(rst_n),
      .hit_lo(match_vec[2*g]), .hit_hi(match_vec[2*g+1]),
      .tim_lo(tim_vec[2*g]), .tim_hi(tim_vec[2*g+1]),
      .chain_lo(cfg[2*g].chain), .chain_hi(cfg[2*g+1].chain),
      .fire_lo(fire_vec[2*g]), .fire_hi(fire_vec[2*g+1]),
      .chained(chained[g])
    );
  end

  // combined trap: current-instruction timing wins over next-instruction timing
  assign now_fire    = fire_vec & ~tim_vec;
  assign trap_req    = |fire_vec;
  assign trap_timing = trap_req && !(|now_fire);
  assign trap_action = |(fire_vec & act_vec);

  a_r10_fire_within_match: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_vec & ~match_vec) == '0);
  a_r7_req_any: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req == (fire_vec != '0));
  a_r7_now_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_vec & ~tim_vec) != '0 |-> !trap_timing);
  a_r3_fetch_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld |-> (match_vec & FETCH_MASK) == '0);
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(!rst_n) |-> match_vec == '0 && !trap_req);
endmodule

// File: tb/dbg_trig_unit_tb.sv
module dbg_trig_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic        cfg_en = 1'b0, cfg_sel = 1'b0, cfg_timing = 1'b0;
  logic        cfg_action = 1'b0, cfg_chain = 1'b0;
  logic [1:0]  cfg_mtype = '0;
  logic [63:0] cfg_value = '0;
  logic        fetch_vld = 1'b0, load_vld = 1'b0, store_vld = 1'b0;
  logic [63:0] fetch_pc = '0, load_addr = '0, store_addr = '0;
  logic [9:0]  match_vec, fire_vec;
  logic        trap_req, trap_timing, trap_action;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [9:0] m;
    logic [9:0] f;
    logic       r;
    logic       t;
    logic       a;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_trig_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_mtype(cfg_mtype), .cfg_sel(cfg_sel), .cfg_timing(cfg_timing),
    .cfg_action(cfg_action), .cfg_chain(cfg_chain), .cfg_value(cfg_value),
    .fetch_vld(fetch_vld), .fetch_pc(fetch_pc), .load_vld(load_vld),
    .load_addr(load_addr), .store_vld(store_vld), .store_addr(store_addr),
    .match_vec(match_vec), .fire_vec(fire_vec), .trap_req(trap_req),
    .trap_timing(trap_timing), .trap_action(trap_action)
  );

  // driver: one vector per cycle, applied on the falling edge
  task automatic vec(input bit we, input bit fv, input logic [63:0] fa,
                     input bit lv, input logic [63:0] la, input bit sv,
                     input logic [63:0] sa, input logic [9:0] em, input logic [9:0] ef,
                     input bit er, input bit et, input bit ea, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_we = we;
    fetch_vld = fv; fetch_pc = fa;
    load_vld = lv;  load_addr = la;
    store_vld = sv; store_addr = sa;
    e.m = em; e.f = ef; e.r = er; e.t = et; e.a = ea; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  task automatic set_cfg(input int idx, input bit en, input logic [1:0] mt, input bit sel,
                         input bit tim, input bit act, input bit ch, input logic [63:0] val);
    cfg_idx = 4'(idx); cfg_en = en; cfg_mtype = mt; cfg_sel = sel;
    cfg_timing = tim; cfg_action = act; cfg_chain = ch; cfg_value = val;
  endtask

  // write with idle events: every output must stay 0 during the write cycle
  task automatic cfg(input int idx, input bit en, input logic [1:0] mt, input bit sel,
                     input bit tim, input bit act, input bit ch, input logic [63:0] val);
    @(negedge clk);
    set_cfg(idx, en, mt, sel, tim, act, ch, val);
    vec(1, 0, 0, 0, 0, 0, 0, 10'h0, 10'h0, 0, 0, 0, "R8 write cycle idle");
  endtask

  // monitor: compares a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (match_vec !== e.m || fire_vec !== e.f || trap_req !== e.r ||
            trap_timing !== e.t || trap_action !== e.a) begin
          n_bad++;
          $display("FAIL %s: got m=%h f=%h r=%b t=%b a=%b, exp m=%h f=%h r=%b t=%b a=%b",
                   e.tag, match_vec, fire_vec, trap_req, trap_timing, trap_action,
                   e.m, e.f, e.r, e.t, e.a);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing enabled after reset
    vec(0, 1, 0, 1, 0, 1, 0, 10'h0, 10'h0, 0, 0, 0, "R1 reset state");

    // T0: fetch, equal 0x1000, timing 0, action 1
    cfg(0, 1, 2'd0, 0, 0, 1, 0, 64'h1000);
    vec(0, 1, 64'h1000, 0, 0, 0, 0, 10'h001, 10'h001, 1, 0, 1, "R2 equal hit");
    vec(0, 1, 64'h1004, 0, 0, 0, 0, 10'h000, 10'h000, 0, 0, 0, "R2 equal miss");
    vec(0, 0, 64'h1000, 1, 64'h1000, 1, 64'h1000, 10'h0, 10'h0, 0, 0, 0, "R3 other sources");

    // T1: fetch, equal 0x1000, timing 1, action 0 (unchained)
    cfg(1, 1, 2'd0, 0, 1, 0, 0, 64'h1000);
    vec(0, 1, 64'h1000, 0, 0, 0, 0, 10'h003, 10'h003, 1, 0, 1, "R7 mixed timing");
    // chain pair 0 with differing timing
    cfg(0, 1, 2'd0, 0, 0, 1, 1, 64'h1000);
    vec(0, 1, 64'h1000, 0, 0, 0, 0, 10'h003, 10'h000, 0, 0, 0, "R5 timing mismatch");
    cfg(0, 1, 2'd0, 0, 1, 1, 1, 64'h1000);
    vec(0, 1, 64'h1000, 0, 0, 0, 0, 10'h003, 10'h003, 1, 1, 1, "R4 chained both R7");
    cfg(1, 1, 2'd0, 0, 1, 0, 0, 64'h2000);
    vec(0, 1, 64'h1000, 0, 0, 0, 0, 10'h001, 10'h000, 0, 0, 0, "R4 chained one R10");

    // pair 3: fetch with store, chained
    cfg(6, 1, 2'd0, 0, 0, 0, 1, 64'h4000);
    cfg(7, 1, 2'd0, 0, 0, 0, 0, 64'h5000);
    vec(0, 1, 64'h4000, 0, 0, 1, 64'h5000, 10'h0C0, 10'h0C0, 1, 0, 0, "R4 cross source");
    vec(0, 1, 64'h4000, 0, 0, 0, 0, 10'h040, 10'h000, 0, 0, 0, "R4 cross half");

    // pair 1: store with store, chain request ignored
    cfg(2, 1, 2'd0, 0, 0, 0, 1, 64'h6000);
    cfg(3, 1, 2'd0, 0, 1, 0, 1, 64'h7000);
    vec(0, 0, 0, 0, 0, 1, 64'h6000, 10'h004, 10'h004, 1, 0, 0, "R6 store chain ignored");

    // load triggers: masked, >=, <
    cfg(4, 1, 2'd1, 0, 0, 0, 0, 64'h2007);
    cfg(5, 1, 2'd2, 0, 1, 1, 0, 64'h3000);
    cfg(9, 1, 2'd3, 0, 0, 0, 0, 64'h100);
    vec(0, 0, 0, 1, 64'h200C, 0, 0, 10'h010, 10'h010, 1, 0, 0, "R2 masked inside");
    vec(0, 0, 0, 1, 64'h2010, 0, 0, 10'h000, 10'h000, 0, 0, 0, "R2 masked outside");
    vec(0, 0, 0, 1, 64'h3000, 0, 0, 10'h020, 10'h020, 1, 1, 1, "R2 ge equal");
    vec(0, 0, 0, 1, 64'h2FFF, 0, 0, 10'h000, 10'h000, 0, 0, 0, "R2 ge below");
    vec(0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 10'h020, 10'h020, 1, 1, 1, "R2 ge top unsigned");
    vec(0, 0, 0, 1, 64'h80, 0, 0, 10'h200, 10'h200, 1, 0, 0, "R2 lt hit");
    vec(0, 0, 0, 1, 64'h100, 0, 0, 10'h000, 10'h000, 0, 0, 0, "R2 lt boundary");

    // out-of-range index ignored
    cfg(12, 1, 2'd0, 0, 0, 1, 0, 64'h9000);
    vec(0, 1, 64'h9000, 0, 0, 1, 64'h9000, 10'h000, 10'h000, 0, 0, 0, "R8 index 12 ignored");
    vec(0, 0, 0, 1, 64'h200C, 0, 0, 10'h010, 10'h010, 1, 0, 0, "R8 trigger 4 intact");

    // write and event in one cycle: old setting applies, new one next cycle
    @(negedge clk);
    set_cfg(4, 0, 2'd1, 0, 0, 0, 0, 64'h2007);
    vec(1, 0, 0, 1, 64'h200C, 0, 0, 10'h010, 10'h010, 1, 0, 0, "R8 old setting in write cycle");
    vec(0, 0, 0, 1, 64'h200C, 0, 0, 10'h000, 10'h000, 0, 0, 0, "R8 new setting next cycle");

    // select 1 never matches
    cfg(9, 1, 2'd3, 1, 0, 0, 0, 64'h100);
    vec(0, 0, 0, 1, 64'h80, 0, 0, 10'h000, 10'h000, 0, 0, 0, "R9 data select");

    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule